// File: doc/BRIEF.md
# Phase-Correct PWM Compare Timer

This block is an 8-bit up/down timer that produces a symmetric, phase-correct PWM waveform. On each cycle where the prescaler tick strobe is high, the count moves one step. It climbs from zero to the all-ones TOP value, turns round, and falls back to zero. Each endpoint holds for a single tick. The count is compared against a compare value. A match drives the waveform output, and the action taken depends on a 2-bit output mode and on the direction the counter was travelling.

Software can read the count at any time and can overwrite it. A counter write suppresses the compare match on the next tick. Compare writes go into a buffer, and the buffered value becomes active only when the counter arrives at TOP, so a period never sees two different compare values. A compare value equal to TOP is a special case: its action is applied when the counter arrives at TOP.

Top module: `pcpwm_timer`

## Requirements
- R1: After reset the count reads 0, the direction is up, the active and buffered compare values are 0, and `wave_o` and `wave_oe` are low.
- R2: A counter write loads `cnt_wdata`, and `cnt_rdata` shows it one cycle later. The write wins over a tick in the same cycle. The counting direction is left unchanged.
- R3: The count changes only in cycles where `tick` is high and no counter write is made.
- R4: The count runs 0,1,…,255,254,…,1,0,1,… so that each endpoint holds for exactly one tick and the period is 510 ticks. If the count sits at 255 when a tick arrives, it always steps down. If it sits at 0, it always steps up.
- R5: A compare write fills a buffer only. On a tick, the buffer is copied into the active compare value when the count arrives at 255, and the match evaluated in that same cycle already uses the new value.
- R6: Modes 00 and 01 (`com_mode`) disconnect the output: `wave_oe` is 0, `wave_o` is 0, and the stored output level is not updated.
- R7: A match is an arrival of the count at the active compare value on a tick, taking the direction of travel into that value. In mode 10, an upward match drives the output to 0 and a downward match drives it to 1.
- R8: In mode 11, an upward match drives the output to 1 and a downward match drives it to 0.
- R9: When the active compare value is 255, arriving at 255 applies the downward action: set in mode 10, clear in mode 11.
- R10: After a counter write, the first tick that follows produces no match, even if the count arrives at the compare value.
- R11: A compare value of 0 is reached only while counting down, so in mode 10 the output settles permanently high and in mode 11 permanently low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaler count enable strobe |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write value |
| cmp_we | input | 1 | Compare buffer write strobe |
| cmp_wdata | input | 8 | Compare write value |
| cnt_rdata | output | 8 | Current count |
| com_mode | input | 2 | Output mode: 00/01 disconnected, 10 clear-up/set-down, 11 set-up/clear-down |
| wave_o | output | 1 | PWM waveform |
| wave_oe | output | 1 | Waveform output enable |

## Verification
A counter write and a tick can land in the same cycle, and so can the suppressed compare match and the counter's arrival at the compare value. The bench raises `tick` together with `cnt_wdata`, and expects the written value rather than a stepped one. It then parks the counter one below the compare value while counting up, ticks once, and expects the count to reach the compare value with the output unchanged. A control run that writes two below shows that the match fires when no write precedes the arrival tick.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;
   typedef enum logic [1:0] {
      COM_OFF   = 2'b00,
      COM_RSVD  = 2'b01,
      COM_CLRUP = 2'b10,
      COM_SETUP = 2'b11
   } com_mode_e;

   function automatic logic drives_pin(input logic [1:0] m);
      return m[1];
   endfunction
endpackage

// File: rtl/pcpwm_updown.sv
module pcpwm_updown #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] cnt,
   output logic [W-1:0] nxt,
   output logic         nxt_up
);
   localparam logic [W-1:0] TOPV  = {W{1'b1}};
   localparam logic [W-1:0] TOPM1 = TOPV - W'(1);
   localparam logic [W-1:0] ONE   = W'(1);

   logic dir_up;

   always_comb begin
      if (cnt == '0)        nxt_up = 1'b1;
      else if (cnt == TOPV) nxt_up = 1'b0;
      else                  nxt_up = dir_up;
      nxt = nxt_up ? cnt + ONE : cnt - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         dir_up <= 1'b1;
      end else if (ld) begin
         cnt <= ld_val;
      end else if (step) begin
         cnt <= nxt;
         if (nxt == TOPV)    dir_up <= 1'b0;
         else if (nxt == '0) dir_up <= 1'b1;
         else                dir_up <= nxt_up;
      end
   end

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> cnt == $past(ld_val));
   assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !ld) |=> $stable(cnt));
   assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld) |=> (cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE));
   assert_top_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld && cnt == TOPV) |=> cnt == TOPM1);
   assert_zero_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld && cnt == '0) |=> cnt == ONE);
endmodule

// File: rtl/pcpwm_cmpbuf.sv
module pcpwm_cmpbuf #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         upd,
   output logic [W-1:0] cmp_eff
);
   logic [W-1:0] shadow;
   logic [W-1:0] active;

   assign cmp_eff = upd ? shadow : active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
         active <= '0;
      end else begin
         if (wr)  shadow <= wdata;
         if (upd) active <= shadow;
      end
   end

   assert_hold_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(active));
   assert_take_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> active == $past(shadow));
endmodule

// File: rtl/pcpwm_wave.sv
module pcpwm_wave #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   mode,
   input  logic         step,
   input  logic         cnt_we,
   input  logic [W-1:0] nxt,
   input  logic         nxt_up,
   input  logic [W-1:0] cmp,
   output logic         wave_o,
   output logic         wave_oe
);
   import pcpwm_pkg::*;
   localparam logic [W-1:0] TOPV = {W{1'b1}};

   logic blk;
   logic wave_q;
   logic hit;
   logic act_up;

   assign hit     = step && !blk && (nxt == cmp);
   assign act_up  = nxt_up && (nxt != TOPV);
   assign wave_oe = drives_pin(mode);
   assign wave_o  = wave_q & wave_oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk    <= 1'b0;
         wave_q <= 1'b0;
      end else begin
         if (cnt_we)    blk <= 1'b1;
         else if (step) blk <= 1'b0;
         if (hit && mode[1])
            wave_q <= act_up ? mode[0] : ~mode[0];
      end
   end

   assert_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (blk && step) |=> $stable(wave_q));
   assert_off_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mode[1] |=> $stable(wave_q));
   assert_clrup_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !blk && nxt == cmp && mode == COM_CLRUP && nxt_up && nxt != TOPV) |=> !wave_q);
   assert_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !blk && nxt == cmp && mode == COM_SETUP && nxt_up && nxt != TOPV) |=> wave_q);
   assert_top_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !blk && nxt == TOPV && cmp == TOPV && mode == COM_CLRUP) |=> wave_q);
endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             cmp_we,
   input  logic [CNT_W-1:0] cmp_wdata,
   output logic [CNT_W-1:0] cnt_rdata,
   input  logic [1:0]       com_mode,
   output logic             wave_o,
   output logic             wave_oe
);
   localparam logic [CNT_W-1:0] TOPV = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("pcpwm_timer: CNT_W must lie in 2..32");
      end
   endgenerate

   logic             step;
   logic [CNT_W-1:0] nxt;
   logic             nxt_up;
   logic [CNT_W-1:0] cmp_eff;
   logic             upd;

   assign step = tick && !cnt_we;
   assign upd  = step && (nxt == TOPV);

   pcpwm_updown #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step),
      .ld     (cnt_we),
      .ld_val (cnt_wdata),
      .cnt    (cnt_rdata),
      .nxt    (nxt),
      .nxt_up (nxt_up)
   );

   pcpwm_cmpbuf #(.W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cmp_we),
      .wdata   (cmp_wdata),
      .upd     (upd),
      .cmp_eff (cmp_eff)
   );

   pcpwm_wave #(.W(CNT_W)) u_wave (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (com_mode),
      .step    (step),
      .cnt_we  (cnt_we),
      .nxt     (nxt),
      .nxt_up  (nxt_up),
      .cmp     (cmp_eff),
      .wave_o  (wave_o),
      .wave_oe (wave_oe)
   );

   assert_disc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !com_mode[1] |-> (!wave_oe && !wave_o));
endmodule

// File: tb/pcpwm_timer_tb.sv
module pcpwm_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       cnt_we = 1'b0;
   logic [7:0] cnt_wdata = 8'h00;
   logic       cmp_we = 1'b0;
   logic [7:0] cmp_wdata = 8'h00;
   logic [7:0] cnt_rdata;
   logic [1:0] com_mode = 2'b00;
   logic       wave_o;
   logic       wave_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   pcpwm_timer #(.CNT_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we),
      .cnt_wdata(cnt_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
      .cnt_rdata(cnt_rdata), .com_mode(com_mode),
      .wave_o(wave_o), .wave_oe(wave_oe)
   );

   // fields: mode[20:19] compare[18:11] expected-high-ticks[10:1] expected-oe[0]
   localparam int NV = 10;
   localparam logic [20:0] VEC [NV] = '{
      {2'd2, 8'h40, 10'd128, 1'b1},  // R7
      {2'd3, 8'h40, 10'd382, 1'b1},  // R8
      {2'd2, 8'h01, 10'd2,   1'b1},  // R7
      {2'd3, 8'hFE, 10'd2,   1'b1},  // R8
      {2'd2, 8'hFF, 10'd510, 1'b1},  // R9
      {2'd3, 8'hFF, 10'd0,   1'b1},  // R9
      {2'd2, 8'h00, 10'd510, 1'b1},  // R11
      {2'd3, 8'h00, 10'd0,   1'b1},  // R11
      {2'd0, 8'h40, 10'd0,   1'b0},  // R6
      {2'd1, 8'h40, 10'd0,   1'b0}   // R6
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive one cycle from just after a falling edge to the next falling edge
   task automatic drive(input logic t, input logic we, input logic [7:0] wd,
                        input logic cw, input logic [7:0] cd);
      tick = t; cnt_we = we; cnt_wdata = wd; cmp_we = cw; cmp_wdata = cd;
      @(negedge clk);
      tick = 1'b0; cnt_we = 1'b0; cmp_we = 1'b0;
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
   endtask

   task automatic wcnt(input logic [7:0] v);
      drive(1'b0, 1'b1, v, 1'b0, 8'h00);
   endtask

   task automatic wcmp(input logic [7:0] v);
      drive(1'b0, 1'b0, 8'h00, 1'b1, v);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 count", cnt_rdata, 0);
      check("R1 wave", wave_o, 0);
      check("R1 oe", wave_oe, 0);

      // R3 no tick, no movement
      for (int i = 0; i < 5; i++) drive(1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
      check("R3 idle", cnt_rdata, 0);
      step(3);
      check("R3 counts on tick", cnt_rdata, 3);

      // R2 write wins over tick in same cycle
      drive(1'b1, 1'b1, 8'h40, 1'b0, 8'h00);
      check("R2 write beats tick", cnt_rdata, 8'h40);

      // R4 turnaround at top
      wcnt(8'hFE);
      step(1);
      check("R4 reach top", cnt_rdata, 8'hFF);
      step(1);
      check("R4 turn at top", cnt_rdata, 8'hFE);
      // R2 direction kept across a write
      wcnt(8'h80);
      step(1);
      check("R2 direction kept", cnt_rdata, 8'h7F);
      wcnt(8'h01);
      step(1);
      check("R4 reach zero", cnt_rdata, 0);
      step(1);
      check("R4 turn at zero", cnt_rdata, 1);

      // table of mode/compare vectors: high ticks over one 510-tick period
      for (int v = 0; v < NV; v++) begin
         int highs;
         com_mode = VEC[v][20:19];
         wcmp(VEC[v][18:11]);
         step(1020);
         highs = 0;
         for (int k = 0; k < 510; k++) begin
            step(1);
            if (wave_o) highs++;
         end
         check($sformatf("R6/R7/R8/R9/R11 vec%0d oe", v), wave_oe, int'(VEC[v][0]));
         check($sformatf("R6/R7/R8/R9/R11 vec%0d highs", v), highs, int'(VEC[v][10:1]));
      end

      // R10 block after a counter write, mode 11, compare 0x50
      com_mode = 2'b11;
      wcmp(8'h50);
      wcnt(8'h00);
      step(1);
      wcnt(8'hFE);
      step(1);
      step(255);
      check("R8 down clear", cnt_rdata, 0);
      step(1);
      check("R8 low before up match", wave_o, 0);
      wcnt(8'h4F);
      step(1);
      check("R10 count arrived", cnt_rdata, 8'h50);
      check("R10 match blocked", wave_o, 0);
      wcnt(8'h4E);
      step(2);
      check("R10 unblocked match", wave_o, 1);

      // R5 compare change waits for top
      wcmp(8'h60);
      step(8'h10);
      check("R5 count at new value", cnt_rdata, 8'h60);
      check("R5 no early match", wave_o, 1);
      step(8'h9F);
      check("R5 at top", cnt_rdata, 8'hFF);
      step(8'h9E);
      check("R5 before new match", wave_o, 1);
      step(1);
      check("R5 new value active", wave_o, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule